// File: doc/BRIEF.md
# Horizontal Sync and Color Burst Gate Generator

This block times one video line in character clocks and drives the horizontal sync pulse together with the color burst enable for a composite encoder. A free-running character tick comes in at dot-clock granularity. The block uses every tick in full-rate modes. In the 40-column text mode it uses only every second tick, so the same register values give a line, and a sync pulse, twice as long in dots.

The burst enable is a window of fixed length in dot clocks. It opens a programmable number of dots after the leading edge of sync, and it is then ANDed with sync itself. If a mode runs the character clock twice as fast and software keeps the old sync width, the pulse shrinks to half its length and the burst is cut short. That is the real behaviour of such hardware, and the block models it on purpose. The monochrome graphics mode never drives the burst. The line length, sync position and width, burst delay and mode are captured only at the end of a line, so a write never disturbs the line in progress.

Top module: `syncBurstGen`

## Requirements
- R1: The character position advances by exactly one on each used character tick and holds otherwise. Mode code 0 (40-column text) uses every second tick. Codes 1 (80-column text), 2 (color graphics) and 3 (monochrome graphics) use every tick.
- R2: The position counts from 0 up to the programmed total and then returns to 0. `lineEnd` is high for the whole character period in which the position equals the total, so a line lasts total+1 character periods.
- R3: `hSync` is high from the character where the position equals the sync start, for sync-width character periods. A width of 0 gives no pulse.
- R4: The burst window opens exactly burst-delay dot clocks after the first dot of sync and stays open for BURST_LEN dot clocks (9 by default).
- R5: `burstEn` is the burst window ANDed with `hSync`, so a sync pulse shorter than delay+BURST_LEN dots truncates the burst.
- R6: In mode code 3 `burstEn` never goes high, while sync timing is unchanged.
- R7: Changes to the total, sync start, sync width, burst delay and mode inputs take effect only at the end of the current line.
- R8: While reset is held, the position is 0 and `hSync`, `burstEn` and `lineEnd` are low, provided the total is nonzero and the sync start is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Synchronous active-low reset |
| charTick | input | 1 | Full-rate character tick, one dot clock wide |
| modeIn | input | 2 | Mode code: 0 text40, 1 text80, 2 color graphics, 3 monochrome graphics |
| totalIn | input | CNT_W | Last character position of the line |
| syncStartIn | input | CNT_W | Character position where sync begins |
| syncWidthIn | input | CNT_W | Sync width in character clocks |
| burstDelayIn | input | DLY_W | Dot clocks from sync leading edge to burst start |
| charEn | output | 1 | Used character clock enable |
| lineEnd | output | 1 | High while the position equals the total |
| hPos | output | CNT_W | Current character position |
| hSync | output | 1 | Horizontal sync pulse |
| burstEn | output | 1 | Color burst enable |

## Verification
The bench keeps the registers fixed and switches from the half-rate mode to a full-rate mode. The sync pulse must shrink from 16 to 8 dots and the burst from 9 to 4 dots. A design that counted sync in dots, or did not gate the burst with sync, would keep both lengths. The bench measures the burst offset from the sync edge with delays of 0, 4 and 10. An off-by-one in the dot counter moves the offset, and a missing AND lets the burst run past a short pulse. The bench changes the sync width in the middle of an active pulse and expects the pulse to keep its old length. A design with transparent registers would stretch that pulse. A width of 0 must give no sync, and the monochrome mode must give sync with no burst.

// File: rtl/syncBurstPkg.sv
package syncBurstPkg;

  typedef enum logic [1:0] {
    MODE_TEXT40    = 2'd0,
    MODE_TEXT80    = 2'd1,
    MODE_GFX_COLOR = 2'd2,
    MODE_GFX_MONO  = 2'd3
  } vidMode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic charEn;
    logic lineEnd;
    logic syncOn;
    logic monoMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/syncBurstCtrl.sv
module syncBurstCtrl
  import syncBurstPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charTick,
  input  logic [1:0]       modeIn,
  input  logic [CNT_W-1:0] totalIn,
  input  logic [CNT_W-1:0] syncStartIn,
  input  logic [CNT_W-1:0] syncWidthIn,
  input  logic [DLY_W-1:0] burstDelayIn,
  output ctrlStrobe_t      stb,
  output logic [CNT_W-1:0] hPos,
  output logic [DLY_W-1:0] burstDelayQ
);

  vidMode_e         modeQ;
  logic [CNT_W-1:0] totalQ;
  logic [CNT_W-1:0] syncStartQ;
  logic [CNT_W-1:0] syncWidthQ;
  logic [CNT_W-1:0] hCount;
  logic             halfPhase;
  logic             halfRate;
  logic             nextHalf;
  logic             charEn;
  logic             atTotal;
  logic             lineDone;
  logic [CNT_W:0]   syncOffset;
  logic             syncOn;

  assign halfRate = (modeQ == MODE_TEXT40);
  assign nextHalf = (vidMode_e'(modeIn) == MODE_TEXT40);
  assign charEn   = charTick & (~halfRate | ~halfPhase);
  assign atTotal  = (hCount == totalQ);
  assign lineDone = charEn & atTotal;

  // offset into the sync pulse, one bit wider so the compare cannot wrap
  assign syncOffset = {1'b0, hCount} - {1'b0, syncStartQ};
  assign syncOn     = (hCount >= syncStartQ) && (syncOffset < {1'b0, syncWidthQ});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCount      <= '0;
      halfPhase   <= 1'b0;
      modeQ       <= vidMode_e'(modeIn);
      totalQ      <= totalIn;
      syncStartQ  <= syncStartIn;
      syncWidthQ  <= syncWidthIn;
      burstDelayQ <= burstDelayIn;
    end else begin
      if (charEn) begin
        hCount <= atTotal ? '0 : hCount + 1'b1;
      end
      if (lineDone) begin
        // shadow registers load only at the line boundary
        modeQ       <= vidMode_e'(modeIn);
        totalQ      <= totalIn;
        syncStartQ  <= syncStartIn;
        syncWidthQ  <= syncWidthIn;
        burstDelayQ <= burstDelayIn;
        halfPhase   <= nextHalf;
      end else if (charTick && halfRate) begin
        halfPhase <= ~halfPhase;
      end
    end
  end

  assign hPos         = hCount;
  assign stb.charEn   = charEn;
  assign stb.lineEnd  = atTotal;
  assign stb.syncOn   = syncOn;
  assign stb.monoMode = (modeQ == MODE_GFX_MONO);

endmodule

// File: rtl/syncBurstDatapath.sv
module syncBurstDatapath
  import syncBurstPkg::*;
#(
  parameter int DLY_W     = 5,
  parameter int BURST_LEN = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [DLY_W-1:0] burstDelayQ,
  output logic             hSync,
  output logic             burstEn
);

  localparam int SPAN  = (1 << DLY_W) - 1 + BURST_LEN;
  localparam int DOT_W = $clog2(SPAN + 1);
  localparam logic [DOT_W-1:0] DOT_SAT = DOT_W'(SPAN);
  localparam logic [DOT_W-1:0] LEN_D   = DOT_W'(BURST_LEN);

  logic             syncQ;
  logic             syncRise;
  logic [DOT_W-1:0] dotCnt;
  logic [DOT_W-1:0] dotsSince;
  logic [DOT_W-1:0] delayExt;
  logic             window;

  assign syncRise  = stb.syncOn & ~syncQ;
  assign dotsSince = syncRise ? '0 : dotCnt;
  assign delayExt  = DOT_W'(burstDelayQ);
  assign window    = (dotsSince >= delayExt) && (dotsSince < delayExt + LEN_D);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 1'b0;
      dotCnt <= DOT_SAT;
    end else begin
      syncQ  <= stb.syncOn;
      dotCnt <= (dotsSince == DOT_SAT) ? DOT_SAT : dotsSince + 1'b1;
    end
  end

  assign hSync   = stb.syncOn;
  assign burstEn = window & stb.syncOn & ~stb.monoMode;

endmodule

// File: rtl/syncBurstGen.sv
module syncBurstGen
  import syncBurstPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DLY_W     = 5,
  parameter int BURST_LEN = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             charTick,
  input  logic [1:0]       modeIn,
  input  logic [CNT_W-1:0] totalIn,
  input  logic [CNT_W-1:0] syncStartIn,
  input  logic [CNT_W-1:0] syncWidthIn,
  input  logic [DLY_W-1:0] burstDelayIn,
  output logic             charEn,
  output logic             lineEnd,
  output logic [CNT_W-1:0] hPos,
  output logic             hSync,
  output logic             burstEn
);

  ctrlStrobe_t      stb;
  logic [DLY_W-1:0] burstDelayQ;
  logic             monoLive;
  logic             delayZero;

  syncBurstCtrl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .charTick(charTick), .modeIn(modeIn),
    .totalIn(totalIn), .syncStartIn(syncStartIn), .syncWidthIn(syncWidthIn),
    .burstDelayIn(burstDelayIn), .stb(stb), .hPos(hPos), .burstDelayQ(burstDelayQ)
  );

  syncBurstDatapath #(.DLY_W(DLY_W), .BURST_LEN(BURST_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .burstDelayQ(burstDelayQ),
    .hSync(hSync), .burstEn(burstEn)
  );

  assign charEn    = stb.charEn;
  assign lineEnd   = stb.lineEnd;
  assign monoLive  = stb.monoMode;
  assign delayZero = (burstDelayQ == '0);

endmodule

// File: rtl/syncBurstGen_chk.sv
module syncBurstGen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             charEn,
  input logic             lineEnd,
  input logic [CNT_W-1:0] hPos,
  input logic             hSync,
  input logic             burstEn,
  input logic             monoLive,
  input logic             delayZero
);

  AST_ADVANCE_ON_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    (charEn && !lineEnd) |=> (hPos == CNT_W'($past(hPos) + 1'b1))); // R1

  AST_HOLD_WITHOUT_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    !charEn |=> $stable(hPos)); // R1

  AST_WRAP_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    (charEn && lineEnd) |=> (hPos == '0)); // R2

  AST_SYNC_ON_CHAR_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(charEn) |-> $stable(hSync)); // R3

  AST_BURST_FIRST_DOT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hSync) |-> (burstEn == (delayZero && !monoLive))); // R4

  AST_BURST_INSIDE_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    burstEn |-> hSync); // R5

  AST_MONO_NO_BURST: assert property (@(posedge clk) disable iff (!rstN)
    monoLive |-> !burstEn); // R6

endmodule

bind syncBurstGen syncBurstGen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .charEn(charEn), .lineEnd(lineEnd), .hPos(hPos),
  .hSync(hSync), .burstEn(burstEn), .monoLive(monoLive), .delayZero(delayZero)
);

// File: tb/syncBurstGen_tb_top.sv
module syncBurstGen_tb_top;

  localparam int CNT_W = 8;
  localparam int DLY_W = 5;
  localparam int CHAR_DOTS = 8;
  localparam int BLEN = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             charTick = 1'b0;
  logic [1:0]       modeIn = 2'd1;
  logic [CNT_W-1:0] totalIn = 8'd9;
  logic [CNT_W-1:0] syncStartIn = 8'd5;
  logic [CNT_W-1:0] syncWidthIn = 8'd2;
  logic [DLY_W-1:0] burstDelayIn = 5'd4;
  logic             charEn, lineEnd, hSync, burstEn;
  logic [CNT_W-1:0] hPos;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  int mLine, mSync, mBurst, mLe, mMax, mSyncRise, mBurstRise;

  syncBurstGen #(.CNT_W(CNT_W), .DLY_W(DLY_W), .BURST_LEN(BLEN)) dut_i (
    .clk(clk), .rstN(rstN), .charTick(charTick), .modeIn(modeIn),
    .totalIn(totalIn), .syncStartIn(syncStartIn), .syncWidthIn(syncWidthIn),
    .burstDelayIn(burstDelayIn), .charEn(charEn), .lineEnd(lineEnd),
    .hPos(hPos), .hSync(hSync), .burstEn(burstEn)
  );

  always #4 clk = ~clk;

  // full-rate character tick: one dot wide, every CHAR_DOTS dots
  initial begin
    forever begin
      repeat (CHAR_DOTS - 1) begin
        @(negedge clk);
        charTick = 1'b0;
      end
      @(negedge clk);
      charTick = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expBurst(input int syncDots, input int dly);
    int e;
    e = dly + BLEN;
    if (e > syncDots) e = syncDots;
    return (e > dly) ? e - dly : 0;
  endfunction

  // measure exactly one line, from the dot after lineEnd falls to the next fall
  task automatic measureLine();
    int n;
    bit prevLe, prevSync, prevBurst;
    @(negedge clk);
    while (!lineEnd) @(negedge clk);
    while (lineEnd) @(negedge clk);
    n = 0; mSync = 0; mBurst = 0; mLe = 0; mMax = 0;
    mSyncRise = -1; mBurstRise = -1;
    prevLe = 0; prevSync = 0; prevBurst = 0;
    while (!(prevLe && !lineEnd) && n < 5000) begin
      if (hSync) mSync++;
      if (burstEn) mBurst++;
      if (lineEnd) mLe++;
      if (int'(hPos) > mMax) mMax = int'(hPos);
      if (hSync && !prevSync && mSyncRise < 0) mSyncRise = n;
      if (burstEn && !prevBurst && mBurstRise < 0) mBurstRise = n;
      prevLe = lineEnd; prevSync = hSync; prevBurst = burstEn;
      n++;
      @(negedge clk);
    end
    mLine = n;
  endtask

  task automatic settle();
    measureLine();
    measureLine();
  endtask

  task automatic checkLine(input string tag, input int total, input int rate,
                           input int width, input int dly, input bit mono);
    int s;
    s = width * CHAR_DOTS * rate;
    check(mLine == (total + 1) * CHAR_DOTS * rate, {tag, " R1 line dots"}, mLine, (total + 1) * CHAR_DOTS * rate);
    check(mLe == CHAR_DOTS * rate, {tag, " R2 lineEnd dots"}, mLe, CHAR_DOTS * rate);
    check(mMax == total, {tag, " R2 max position"}, mMax, total);
    check(mSync == s, {tag, " R3 sync dots"}, mSync, s);
    if (mono) check(mBurst == 0, {tag, " R6 mono burst"}, mBurst, 0);
    else check(mBurst == expBurst(s, dly), {tag, " R5 burst dots"}, mBurst, expBurst(s, dly));
    if (!mono && expBurst(s, dly) > 0)
      check(mBurstRise - mSyncRise == dly, {tag, " R4 burst offset"}, mBurstRise - mSyncRise, dly);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    check(hPos == 0, "R8 reset hPos", int'(hPos), 0);
    check(!hSync, "R8 reset hSync", int'(hSync), 0);
    check(!burstEn, "R8 reset burstEn", int'(burstEn), 0);
    check(!lineEnd, "R8 reset lineEnd", int'(lineEnd), 0);
    rstN = 1'b1;
  endtask

  task automatic testText80();
    settle();
    checkLine("text80", 9, 1, 2, 4, 0);
  endtask

  task automatic testText40();
    modeIn = 2'd0;
    settle();
    checkLine("text40", 9, 2, 2, 4, 0);
  endtask

  // half-rate with width 1, then full rate with the same width: R5 truncation
  task automatic testDoubledClock();
    syncWidthIn = 8'd1;
    modeIn = 2'd0;
    settle();
    checkLine("half w1", 9, 2, 1, 4, 0);
    modeIn = 2'd2;
    settle();
    checkLine("full w1 R5", 9, 1, 1, 4, 0);
    syncWidthIn = 8'd2;
  endtask

  task automatic testMono();
    modeIn = 2'd3;
    settle();
    checkLine("mono R6", 9, 1, 2, 4, 1);
    modeIn = 2'd1;
  endtask

  task automatic testZeroWidth();
    syncWidthIn = 8'd0;
    settle();
    check(mSync == 0, "R3 zero width sync", mSync, 0);
    check(mBurst == 0, "R3 zero width burst", mBurst, 0);
    syncWidthIn = 8'd2;
  endtask

  task automatic testDelays();
    burstDelayIn = 5'd0;
    settle();
    checkLine("delay0 R4", 9, 1, 2, 0, 0);
    burstDelayIn = 5'd10;
    settle();
    checkLine("delay10 R5", 9, 1, 2, 10, 0);
    burstDelayIn = 5'd4;
  endtask

  // R7: width changed while sync is active must not stretch the current pulse
  task automatic testLineEndUpdate();
    int cnt;
    settle();
    @(negedge clk);
    while (!hSync) @(negedge clk);
    syncWidthIn = 8'd4;
    totalIn = 8'd13;
    cnt = 0;
    while (hSync) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 16, "R7 current pulse keeps old width", cnt, 16);
    settle();
    checkLine("R7 after update", 13, 1, 4, 4, 0);
    syncWidthIn = 8'd2;
    totalIn = 8'd9;
  endtask

  initial begin
    testReset();
    testText80();
    testText40();
    testDoubledClock();
    testMono();
    testZeroWidth();
    testDelays();
    testLineEndUpdate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule